// File: doc/BRIEF.md
# Video Debug Pin Wrapper

This block sits between a small raster game core and a fixed set of 8-bit chip pins. It takes the core's horizontal and vertical pixel counters, a 4-bit offset, raw red, green and blue, a visible flag and both sync pulses. It drives one 8-bit video output bus and one 8-bit debug bus, and it passes a synchronized copy of the external button pins back to the core.

The colour bits get a register stage before they reach the pins. The sync pulses go out without one, so the colour trails the sync pulses by one clock. Two further pins flag the first column and the first row of the raster.

The debug bus carries three things:
- the number of leading zeros in a 24-bit word built from the offset and the two counters;
- a flag that is high when that word is zero;
- two probe signals whose sources are picked by button pin 4.

The buttons idle low and are driven high when pressed.

Top module: `video_dbg_wrapper`

## Requirements
- R1: Each bit of `pin_in` reaches `btn_sync` through two flip-flops. A change applied between edges shows on `btn_sync` after the second following rising edge and not after the first.
- R2: While `rst` is high at a rising edge, every synchronizer flop clears, so `btn_sync` reads 0.
- R3: `vid_out[0]`, `vid_out[1]` and `vid_out[2]` carry red, green and blue. Each holds the value the core presented before the most recent rising edge, which is a one-clock lag.
- R4: A rising edge with `rst` high clears `vid_out[2:0]` to 0.
- R5: `vid_out[3]` follows `core_hs` and `vid_out[4]` follows `core_vs` with no register stage. `vid_out[5]` is always 0.
- R6: `vid_out[6]` is 1 exactly when `h_cnt` is 0. `vid_out[7]` is 1 exactly when `v_cnt` is 0.
- R7: `dbg_out[4:0]` gives the count of leading zeros, from the most significant bit, of the word {offset[3:0], v_cnt[9:0], h_cnt[9:0]}, with offset in the top bits. An all-zero word gives 24.
- R8: `dbg_out[5]` is 1 exactly when that 24-bit word is zero.
- R9: When the synchronized button bit 4 is 0, `dbg_out[6]` is the raw `core_g` and `dbg_out[7]` is the raw `core_r`.
- R10: When the synchronized button bit 4 is 1, `dbg_out[6]` is `core_vis` and `dbg_out[7]` is the raw `core_b`. The select therefore takes effect two edges after `pin_in[4]` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 8 | External button pins, idle low |
| h_cnt | input | 10 | Core horizontal counter |
| v_cnt | input | 10 | Core vertical counter |
| offset | input | 4 | Core offset value |
| core_r | input | 1 | Raw red |
| core_g | input | 1 | Raw green |
| core_b | input | 1 | Raw blue |
| core_vis | input | 1 | Core visible-area flag |
| core_hs | input | 1 | Core horizontal sync |
| core_vs | input | 1 | Core vertical sync |
| btn_sync | output | 8 | Synchronized buttons to the core |
| vid_out | output | 8 | Video pins: RGB, syncs, zero, column 0, row 0 |
| dbg_out | output | 8 | Debug pins: leading-zero count, zero flag, two probes |

## Verification
The leading-zero count is driven to its ends and across the field boundaries of the packed word. These stimuli include an all-zero word, a set top bit, and a lone low bit in each counter. A count that packed the fields in the wrong order, or that returned 23 or 0 for an empty word, gives a wrong value on the debug bus. Colour is sampled right after an edge, so a design that left it unregistered, or that also registered the syncs, shows the wrong lag. The select is toggled through the button pin and checked after one edge and after two. This catches a bypassed synchronizer, a stage too few, and swapped probe sources.

// File: rtl/video_dbg_pkg.sv
package video_dbg_pkg;
  // bit positions on the video pin bus
  localparam int unsigned VP_RED   = 0;
  localparam int unsigned VP_GREEN = 1;
  localparam int unsigned VP_BLUE  = 2;
  localparam int unsigned VP_HS    = 3;
  localparam int unsigned VP_VS    = 4;
  localparam int unsigned VP_SPARE = 5;
  localparam int unsigned VP_COL0  = 6;
  localparam int unsigned VP_ROW0  = 7;
  // button pin that steers the debug probes
  localparam int unsigned BTN_PROBE_SEL = 4;

  typedef enum logic {
    PROBE_COLOUR = 1'b0,
    PROBE_VIS    = 1'b1
  } probe_sel_e;
endpackage

// File: rtl/video_btn_sync.sv
module video_btn_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
    // R1: each stage copies its predecessor one edge later
    a_r1_stage_shift: assert property (@(posedge clk) disable iff (rst)
      run_q |-> stage_q[s] == $past(stage_q[s-1]));
  end

  assign dout = stage_q[STAGES-1];

  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  // R1: the first stage samples the pins
  a_r1_first_stage: assert property (@(posedge clk) disable iff (rst)
    run_q |-> stage_q[0] == $past(din));
  // R2: reset clears the output
  a_r2_reset_clear: assert property (@(posedge clk) rst |=> dout == '0);
endmodule

// File: rtl/video_lzc.sv
module video_lzc #(
  parameter int unsigned W  = 24,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word,
  output logic [CW-1:0] count,
  output logic          is_zero
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (word[i]) count = CW'(W - 1 - i);
    end
  end

  assign is_zero = ~|word;

  // R7/R8: the full count and the zero flag agree
  always_comb begin
    a_r8_zero_vs_count: assert (is_zero == (count == CW'(W)));
  end
endmodule

// File: rtl/video_dbg_mux.sv
module video_dbg_mux
  import video_dbg_pkg::*;
(
  input  probe_sel_e sel,
  input  logic       raw_r,
  input  logic       raw_g,
  input  logic       raw_b,
  input  logic       vis,
  output logic       probe1,
  output logic       probe2
);
  always_comb begin
    unique case (sel)
      PROBE_VIS: begin
        probe1 = vis;
        probe2 = raw_b;
      end
      default: begin
        probe1 = raw_g;
        probe2 = raw_r;
      end
    endcase
  end

  always_comb begin
    // R9: colour probes when select is low
    if (sel == PROBE_COLOUR) a_r9_colour_probes: assert (probe1 == raw_g && probe2 == raw_r);
    // R10: visible and blue probes when select is high
    if (sel == PROBE_VIS)    a_r10_vis_probes: assert (probe1 == vis && probe2 == raw_b);
  end
endmodule

// File: rtl/video_dbg_wrapper.sv
module video_dbg_wrapper
  import video_dbg_pkg::*;
#(
  parameter int unsigned PIN_W       = 8,
  parameter int unsigned H_W         = 10,
  parameter int unsigned V_W         = 10,
  parameter int unsigned OFS_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [PIN_W-1:0]                       pin_in,
  input  logic [H_W-1:0]                         h_cnt,
  input  logic [V_W-1:0]                         v_cnt,
  input  logic [OFS_W-1:0]                       offset,
  input  logic                                   core_r,
  input  logic                                   core_g,
  input  logic                                   core_b,
  input  logic                                   core_vis,
  input  logic                                   core_hs,
  input  logic                                   core_vs,
  output logic [PIN_W-1:0]                       btn_sync,
  output logic [7:0]                             vid_out,
  output logic [$clog2(OFS_W+V_W+H_W+1)+2:0]     dbg_out
);
  localparam int unsigned LZ_W  = OFS_W + V_W + H_W;
  localparam int unsigned LZ_CW = $clog2(LZ_W + 1);

  // button synchronizer
  video_btn_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(btn_sync)
  );

  // registered colour
  logic [2:0] rgb_q;
  always_ff @(posedge clk) begin
    if (rst) rgb_q <= '0;
    else     rgb_q <= {core_b, core_g, core_r};
  end

  always_comb begin
    vid_out           = '0;
    vid_out[VP_RED]   = rgb_q[0];
    vid_out[VP_GREEN] = rgb_q[1];
    vid_out[VP_BLUE]  = rgb_q[2];
    vid_out[VP_HS]    = core_hs;
    vid_out[VP_VS]    = core_vs;
    vid_out[VP_SPARE] = 1'b0;
    vid_out[VP_COL0]  = (h_cnt == '0);
    vid_out[VP_ROW0]  = (v_cnt == '0);
  end

  // leading-zero count of packed raster state
  logic [LZ_W-1:0]  lz_word;
  logic [LZ_CW-1:0] lz_count;
  logic             lz_zero;
  assign lz_word = {offset, v_cnt, h_cnt};

  video_lzc #(.W(LZ_W)) i_lzc (
    .word(lz_word), .count(lz_count), .is_zero(lz_zero)
  );

  // debug probes
  probe_sel_e probe_sel;
  logic       probe1, probe2;
  assign probe_sel = probe_sel_e'(btn_sync[BTN_PROBE_SEL]);

  video_dbg_mux i_mux (
    .sel(probe_sel), .raw_r(core_r), .raw_g(core_g), .raw_b(core_b),
    .vis(core_vis), .probe1(probe1), .probe2(probe2)
  );

  assign dbg_out = {probe2, probe1, lz_zero, lz_count};

  // R3: colour pins lag the core by one edge
  a_r3_colour_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> vid_out[2:0] == $past({core_b, core_g, core_r}));
  // R4: reset clears colour pins
  a_r4_colour_reset: assert property (@(posedge clk) rst |=> vid_out[2:0] == 3'b000);
  // R7: a set top offset bit yields a zero count
  a_r7_top_bit: assert property (@(posedge clk) disable iff (rst)
    offset[OFS_W-1] |-> dbg_out[LZ_CW-1:0] == '0);
  // R5: spare pin stays low
  a_r5_spare_low: assert property (@(posedge clk) disable iff (rst)
    vid_out[VP_SPARE] == 1'b0);
endmodule

// File: tb/test_video_dbg_wrapper.sv
`timescale 1ns/1ps
module test_video_dbg_wrapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pin_in = '0;
  logic [9:0] h_cnt = '0, v_cnt = '0;
  logic [3:0] offset = '0;
  logic core_r = 0, core_g = 0, core_b = 0, core_vis = 0, core_hs = 0, core_vs = 0;
  logic [7:0] btn_sync, vid_out, dbg_out;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  video_dbg_wrapper i_video_dbg_wrapper (
    .clk(clk), .rst(rst), .pin_in(pin_in), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .offset(offset), .core_r(core_r), .core_g(core_g), .core_b(core_b),
    .core_vis(core_vis), .core_hs(core_hs), .core_vs(core_vs),
    .btn_sync(btn_sync), .vid_out(vid_out), .dbg_out(dbg_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {offset, v, h, rgb(b,g,r), hs, vs, exp_lz}
  typedef struct packed {
    logic [3:0] ofs;
    logic [9:0] v;
    logic [9:0] h;
    logic [2:0] rgb;
    logic       hs;
    logic       vs;
    logic [4:0] lz;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{4'h0, 10'h000, 10'h000, 3'b101, 1'b1, 1'b0, 5'd24},
    '{4'h8, 10'h000, 10'h000, 3'b010, 1'b0, 1'b1, 5'd0},
    '{4'h1, 10'h3FF, 10'h3FF, 3'b111, 1'b1, 1'b1, 5'd3},
    '{4'h0, 10'h200, 10'h000, 3'b001, 1'b0, 1'b0, 5'd4},
    '{4'h0, 10'h001, 10'h3FF, 3'b100, 1'b1, 1'b0, 5'd13},
    '{4'h0, 10'h000, 10'h200, 3'b110, 1'b0, 1'b1, 5'd14},
    '{4'h0, 10'h000, 10'h001, 3'b011, 1'b1, 1'b1, 5'd23},
    '{4'h0, 10'h3FF, 10'h3FF, 3'b000, 1'b0, 1'b0, 5'd4},
    '{4'h4, 10'h000, 10'h005, 3'b010, 1'b1, 1'b0, 5'd1}
  };

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // reset
    pin_in = 8'hFF; core_r = 1; core_g = 1; core_b = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 sync reset", {24'h0, btn_sync}, 32'h0);
    check("R4 colour reset", {29'h0, vid_out[2:0]}, 32'h0);
    pin_in = '0;
    rst = 1'b0;
    @(negedge clk);

    // vector table
    foreach (VECS[i]) begin
      offset = VECS[i].ofs; v_cnt = VECS[i].v; h_cnt = VECS[i].h;
      {core_b, core_g, core_r} = VECS[i].rgb;
      core_hs = VECS[i].hs; core_vs = VECS[i].vs;
      #1;
      check("R7 lz count", {27'h0, dbg_out[4:0]}, {27'h0, VECS[i].lz});
      check("R8 zero flag", {31'h0, dbg_out[5]}, {31'h0, VECS[i].lz == 5'd24});
      check("R5 hs", {31'h0, vid_out[3]}, {31'h0, VECS[i].hs});
      check("R5 vs", {31'h0, vid_out[4]}, {31'h0, VECS[i].vs});
      check("R5 spare", {31'h0, vid_out[5]}, 32'h0);
      check("R6 col0", {31'h0, vid_out[6]}, {31'h0, VECS[i].h == 10'h0});
      check("R6 row0", {31'h0, vid_out[7]}, {31'h0, VECS[i].v == 10'h0});
      check("R9 probe1 green", {31'h0, dbg_out[6]}, {31'h0, VECS[i].rgb[1]});
      check("R9 probe2 red", {31'h0, dbg_out[7]}, {31'h0, VECS[i].rgb[0]});
      @(posedge clk); #1;
      check("R3 colour lag", {29'h0, vid_out[2:0]}, {29'h0, VECS[i].rgb});
      @(negedge clk);
    end

    // R3: colour must not move before the edge
    {core_b, core_g, core_r} = 3'b000;
    @(posedge clk); @(negedge clk);
    {core_b, core_g, core_r} = 3'b111;
    #1;
    check("R3 no early colour", {29'h0, vid_out[2:0]}, 32'h0);

    // R1 and R10: synchronizer latency on the select
    core_vis = 1'b1; core_b = 1'b0; core_g = 1'b0; core_r = 1'b1;
    pin_in = 8'h10;
    @(posedge clk); #1;
    check("R1 one edge", {24'h0, btn_sync}, 32'h0);
    check("R10 select not yet", {31'h0, dbg_out[6]}, 32'h0);
    @(posedge clk); #1;
    check("R1 two edges", {24'h0, btn_sync}, 32'h10);
    check("R10 probe1 vis", {31'h0, dbg_out[6]}, 32'h1);
    check("R10 probe2 blue", {31'h0, dbg_out[7]}, 32'h0);
    core_b = 1'b1; core_vis = 1'b0; #1;
    check("R10 probe2 blue follows", {31'h0, dbg_out[7]}, 32'h1);
    check("R10 probe1 vis follows", {31'h0, dbg_out[6]}, 32'h0);

    // back to colour probes
    @(negedge clk);
    pin_in = 8'h00; core_g = 1'b1; core_r = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R9 probe1 green again", {31'h0, dbg_out[6]}, 32'h1);
    check("R9 probe2 red again", {31'h0, dbg_out[7]}, 32'h0);

    // R4: reset in mid-run clears colour
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R4 colour cleared", {29'h0, vid_out[2:0]}, 32'h0);
    check("R2 sync cleared", {24'h0, btn_sync}, 32'h0);
    rst = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule